// File: doc/BRIEF.md
# Prefix-Gated Binary Match Table

This block is an exact-match lookup table built from flip-flops and comparators. It holds a set of fixed-width words, each with its own occupancy flag. A caller offers a search key, and the block returns which stored words equal it. It also returns whether any word matched and the index of the lowest matching word.

Each word is compared in two pieces. A narrow leading slice of the key, taken from the most significant bits, is compared against every occupied entry in the first pipeline stage. An entry's wide trailing comparator is armed only when that leading slice matched. A comparator that is not armed keeps its operand registers frozen, which saves switching activity, and it reports a miss.

Each entry's trailing comparator is a two-state machine. In `CMP_GATED` its operands are held and it reports no match. In `CMP_ARMED` it compares the latched key slice with the latched stored slice. The transition GATED→ARMED or ARMED→ARMED is taken on a clock edge where a search is offered and the entry is occupied and its leading slice equals the key's. Every other edge takes ARMED→GATED or GATED→GATED. Searches are fully pipelined, and the result appears a fixed two cycles after the key.

Top module: `gated_cam`

## Requirements
- R1: After reset every occupancy flag is clear, `res_valid`, `res_hit` and `res_match` are zero, and a search of any key misses.
- R2: An entry matches only if all WIDTH stored bits equal the key; a difference in bit 0 alone or bit WIDTH-1 alone gives a miss for that entry.
- R3: A search offered with `srch_start` high in one cycle produces `res_valid` high exactly two clock edges later; in every other cycle `res_valid` is low and `res_match` and `res_hit` are zero.
- R4: A new search can be offered in every cycle, and each back-to-back search yields its own result in order.
- R5: The leading slice is bits [WIDTH-1 : WIDTH-PFX_W] and the trailing slice is bits [WIDTH-PFX_W-1 : 0]; an entry with an equal trailing slice but a different leading slice misses, and an entry with an equal leading slice but a different trailing slice misses.
- R6: A write with `wr_valid` low clears that entry's occupancy flag; an unoccupied entry never matches, whatever its contents.
- R7: `res_match` bit i is set when entry i matches; `res_hit` is high when any bit is set; `res_addr` is the lowest index whose bit is set.
- R8: A search offered in the same cycle as a write to an entry sees that entry's old contents and flag; a search offered in the cycle after sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Occupancy flag to store with the word |
| srch_start | input | 1 | Offer a search this cycle |
| srch_key | input | WIDTH | Search key |
| res_valid | output | 1 | Result is present this cycle |
| res_match | output | ENTRIES | One bit per matching entry |
| res_hit | output | 1 | At least one entry matched |
| res_addr | output | AW | Lowest matching entry index |

## Verification
The bench loads words that share a trailing slice but differ in the leading slice, and words that share a leading slice but differ in the trailing slice. A design that compared only one piece, or that let an ungated comparator report, would hit on these. It searches keys off by only bit 0 or only bit 35, places duplicates at entries 5 and 9 to check the lowest-index choice, and uses entry 63 to exercise the top boundary. It also writes or invalidates an entry in the same cycle as a search for it. A design that latched the stored trailing slice one cycle late would mix old and new contents there and report a wrong hit or miss.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // Default geometry of the table.
    localparam int CAM_ENTRIES = 64;
    localparam int CAM_WIDTH   = 36;
    localparam int CAM_PFX_W   = 4;

    // State of one entry's trailing-slice comparator.
    typedef enum logic {
        CMP_GATED = 1'b0,
        CMP_ARMED = 1'b1
    } cmp_state_e;

endpackage

// File: rtl/cam_entry.sv
module cam_entry
    import cam_pkg::*;
#(
    parameter int WIDTH = CAM_WIDTH,
    parameter int PFX_W = CAM_PFX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             srch_start,
    input  logic [WIDTH-1:0] srch_key,
    output logic             match_o
);

    localparam int SFX_W = WIDTH - PFX_W;

    logic [WIDTH-1:0] store_q;
    logic             occ_q;
    cmp_state_e       state_q;
    cmp_state_e       state_d;
    logic [SFX_W-1:0] op_key_q;
    logic [SFX_W-1:0] op_store_q;
    logic             pfx_eq;
    logic             sfx_hit;
    logic             match_q;

    // Word storage: no reset needed, the occupancy flag guards it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= 1'b0;
        end else if (wr_en) begin
            occ_q <= wr_valid;
        end
    end

    // Stage 1: narrow leading-slice compare against current contents.
    assign pfx_eq = srch_start && occ_q &&
                    (store_q[WIDTH-1 -: PFX_W] == srch_key[WIDTH-1 -: PFX_W]);

    always_comb begin
        state_d = pfx_eq ? CMP_ARMED : CMP_GATED;
    end

    // Comparator state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMP_GATED;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand isolation: both operands load only when the entry arms,
    // capturing the stored slice as it was before any same-edge write.
    always_ff @(posedge clk) begin
        if (pfx_eq) begin
            op_key_q   <= srch_key[SFX_W-1:0];
            op_store_q <= store_q[SFX_W-1:0];
        end
    end

    // Stage 2 output decode per state.
    always_comb begin
        unique case (state_q)
            CMP_GATED: sfx_hit = 1'b0;
            CMP_ARMED: sfx_hit = (op_key_q == op_store_q);
            default:   sfx_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= sfx_hit;
        end
    end

    assign match_o = match_q;

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 64,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [AW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = AW'(i);
            end
        end
    end

    assign any = |vec;

endmodule

// File: rtl/gated_cam.sv
module gated_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int WIDTH   = CAM_WIDTH,
    parameter int PFX_W   = CAM_PFX_W,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic               wr_valid,
    input  logic               srch_start,
    input  logic [WIDTH-1:0]   srch_key,
    output logic               res_valid,
    output logic [ENTRIES-1:0] res_match,
    output logic               res_hit,
    output logic [AW-1:0]      res_addr
);

    logic [ENTRIES-1:0] match_vec;
    logic               s1_vld_q;
    logic               s2_vld_q;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            logic sel_wr;
            assign sel_wr = wr_en && (wr_addr == AW'(g));

            cam_entry #(
                .WIDTH (WIDTH),
                .PFX_W (PFX_W)
            ) u_entry (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (sel_wr),
                .wr_data    (wr_data),
                .wr_valid   (wr_valid),
                .srch_start (srch_start),
                .srch_key   (srch_key),
                .match_o    (match_vec[g])
            );
        end
    endgenerate

    // Pipeline occupancy, two stages.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld_q <= 1'b0;
            s2_vld_q <= 1'b0;
        end else begin
            s1_vld_q <= srch_start;
            s2_vld_q <= s1_vld_q;
        end
    end

    cam_prio_enc #(
        .N  (ENTRIES),
        .AW (AW)
    ) u_enc (
        .vec (match_vec),
        .any (res_hit),
        .idx (res_addr)
    );

    assign res_valid = s2_vld_q;
    assign res_match = match_vec;

endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
    parameter int ENTRIES = 64,
    parameter int AW      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch_start,
    input logic               res_valid,
    input logic [ENTRIES-1:0] res_match,
    input logic               res_hit,
    input logic [AW-1:0]      res_addr
);

    logic [1:0] issued_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= '0;
        end else begin
            issued_q <= {issued_q[0], srch_start};
        end
    end

    // R3: result appears exactly two edges after the search.
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == issued_q[1]);

    // R3: outputs are quiet outside a result cycle.
    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_match == '0 && !res_hit));

    // R7: reported address points at a set match bit.
    assert_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_match[res_addr]);

    // R7: no lower-index entry also matched.
    assert_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> ((res_match & ((ENTRIES'(1) << res_addr) - ENTRIES'(1))) == '0));

    // R7: a miss means an empty match vector.
    assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_match == '0));

endmodule

bind gated_cam cam_checker #(
    .ENTRIES (ENTRIES),
    .AW      (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_start (srch_start),
    .res_valid  (res_valid),
    .res_match  (res_match),
    .res_hit    (res_hit),
    .res_addr   (res_addr)
);

// File: tb/gated_cam_tb.sv
module gated_cam_tb;

    localparam int N  = 64;
    localparam int W  = 36;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          srch_start = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic          res_valid;
    logic [N-1:0]  res_match;
    logic          res_hit;
    logic [AW-1:0] res_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [W-1:0] mdl_mem [N];
    logic         mdl_occ [N];

    typedef struct {
        int           due;
        logic [N-1:0] m;
        string        tag;
    } exp_t;
    exp_t sb[$];

    gated_cam u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .srch_start (srch_start),
        .srch_key   (srch_key),
        .res_valid  (res_valid),
        .res_match  (res_match),
        .res_hit    (res_hit),
        .res_addr   (res_addr)
    );

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; expected result from the model
    // before this cycle's write is applied (R8).
    task automatic op(input bit do_w, input int a, input logic [W-1:0] d,
                      input bit v, input bit do_s, input logic [W-1:0] k,
                      input string tag);
        exp_t e;
        @(negedge clk);
        wr_en      = do_w;
        wr_addr    = AW'(a);
        wr_data    = d;
        wr_valid   = v;
        srch_start = do_s;
        srch_key   = k;
        if (do_s) begin
            e.due = cyc + 2;
            e.tag = tag;
            for (int i = 0; i < N; i++) e.m[i] = mdl_occ[i] && (mdl_mem[i] == k);
            sb.push_back(e);
        end
        if (do_w) begin
            mdl_mem[a] = d;
            mdl_occ[a] = v;
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d, input bit v);
        op(1'b1, a, d, v, 1'b0, '0, "");
    endtask

    task automatic srch(input logic [W-1:0] k, input string tag);
        op(1'b0, 0, '0, 1'b0, 1'b1, k, tag);
    endtask

    // Monitor: pops the scoreboard when a result is due.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                int lo;
                e = sb.pop_front();
                lo = 0;
                for (int i = N - 1; i >= 0; i--) if (e.m[i]) lo = i;
                chk(res_valid === 1'b1, e.tag, "res_valid (R3)", N'(res_valid), N'(1));
                chk(res_match === e.m, e.tag, "res_match", res_match, e.m);
                chk(res_hit === (|e.m), e.tag, "res_hit (R7)", N'(res_hit), N'(|e.m));
                if (|e.m)
                    chk(res_addr === AW'(lo), e.tag, "res_addr (R7)", N'(res_addr), N'(lo));
            end else begin
                chk(res_valid === 1'b0, "R3", "idle res_valid", N'(res_valid), N'(0));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl_mem[i] = '0;
            mdl_occ[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(res_valid === 1'b0, "R1", "reset res_valid", N'(res_valid), N'(0));
        chk(res_hit === 1'b0, "R1", "reset res_hit", N'(res_hit), N'(0));
        chk(res_match === '0, "R1", "reset res_match", res_match, '0);
        srch(36'h0_0000_0000, "R1 search after reset");

        wr(5,  36'h1_2345_6789, 1'b1);
        wr(9,  36'h1_2345_6789, 1'b1);
        wr(20, 36'h2_2345_6789, 1'b1);
        wr(30, 36'h1_2345_678A, 1'b1);
        wr(63, 36'hF_FFFF_FFFF, 1'b1);
        wr(40, 36'h0_0000_0000, 1'b0);

        // R4: back-to-back searches every cycle.
        srch(36'h1_2345_6789, "R7 R2 duplicates lowest index");
        srch(36'h2_2345_6789, "R5 prefix differs");
        srch(36'h1_2345_678A, "R5 suffix differs");
        srch(36'hF_FFFF_FFFF, "R2 top entry");
        srch(36'h1_2345_6788, "R2 bit0 differs");
        srch(36'h9_2345_6789, "R2 bit35 differs");
        srch(36'h0_0000_0000, "R6 unoccupied zero entry");
        srch(36'h3_0000_0001, "R4 miss");

        // R8: same-cycle write sees old, next cycle sees new.
        op(1'b1, 2, 36'h3_0000_0001, 1'b1, 1'b1, 36'h3_0000_0001, "R8 same cycle old");
        srch(36'h3_0000_0001, "R8 next cycle new");
        // R6 with R8: invalidate entry 5.
        op(1'b1, 5, 36'h1_2345_6789, 1'b0, 1'b1, 36'h1_2345_6789, "R8 R6 invalidate old");
        srch(36'h1_2345_6789, "R6 invalidated entry skipped");
        // Overwrite entry 63 and search with a gap.
        wr(63, 36'hF_FFFF_FFFE, 1'b1);
        srch(36'hF_FFFF_FFFF, "R8 overwrite old word gone");
        op(1'b0, 0, '0, 1'b0, 1'b0, '0, "");
        srch(36'hF_FFFF_FFFE, "R2 overwrite new word");

        op(1'b0, 0, '0, 1'b0, 1'b0, '0, "");
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R3", "scoreboard drained", N'(sb.size()), N'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule